// File: doc/BRIEF.md
# Delta-Sigma ADC Readout Host

This block is the bus master that reads a 16-bit delta-sigma converter over a three- or four-wire synchronous serial link. A single start pulse runs one complete transaction. The block pulls chip select low and divides the system clock down to a serial clock. On the serial data output it sends a four-bit command word. At the same time it shifts in sixteen result bits from the converter's data line. When chip select rises, it presents the sampled code on a one-cycle valid strobe. The code is given twice: as captured, and as a two's complement value with the mid-scale offset removed.

The converter needs time between reads, and the block measures that time with counters derived from the system clock frequency. After every transaction chip select stays high for at least the worst-case conversion time. Two configuration inputs set the speed and sleep bits of the next command. When a read has put the converter's reference to sleep, the next read is handled in one of two ways, chosen by a third input. Either the block holds chip select low for the reference start-up time before clocking, or it clocks at once and discards that result.

Top module: `adc_read_host`

## Requirements
- R1: While reset is held and right after it, csN is 1, sck is 0, sdi is 0 and resValid is 0. The first read begins no sooner than CONV_CYC = CLK_KHZ*CONV_US/1000 cycles after reset is released.
- R2: The command goes out on sdi MSB first and is sampled at the first four sck rising edges, as the bits 1, 0, cfgSpeed, cfgSleep (the leading 1 and 0 mark a programming write). sdi is 0 at every later rising edge of the read.
- R3: Each read makes exactly 16 sck pulses. sdo is sampled on each rising edge, with the first sample taking bit 15, so the code is assembled MSB first. sck is 0 whenever csN is 1.
- R4: resValid is high for exactly one cycle per reported read. It rises after csN has returned high, and resRaw holds the 16 captured bits.
- R5: resSigned equals resRaw with bit 15 inverted, which is the two's complement of code minus 32768. So 0x8000 gives 0x0000, 0xFFFF gives 0x7FFF and 0x0000 gives 0x8000.
- R6: csN stays high for at least CONV_CYC cycles between the end of one read and the start of the next.
- R7: If the previous read sent sleep = 1 and cfgDropWake = 0, the first sck rise comes at least WAKE_CYC = CLK_KHZ*WAKE_US/1000 cycles after csN falls. In every other case it comes within 2*SCK_HALF cycles.
- R8: If the previous read sent sleep = 1 and cfgDropWake = 1, the read runs without the start-up delay and gives no resValid. Later reads report normally.
- R9: A start pulse that arrives during a read or during the conversion wait has no effect and starts no extra read.
- R10: Once the first sck rise has occurred, every high phase and every low phase of sck lasts exactly SCK_HALF system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one read transaction |
| cfgSpeed | input | 1 | Speed bit sent in the command |
| cfgSleep | input | 1 | Sleep bit sent in the command |
| cfgDropWake | input | 1 | After sleep, discard the first result instead of waiting |
| csN | output | 1 | Converter chip select, active low |
| sck | output | 1 | Serial clock, idles low |
| sdi | output | 1 | Command data to the converter |
| sdo | input | 1 | Result data from the converter |
| resValid | output | 1 | One-cycle strobe for a new result |
| resRaw | output | 16 | Code as received |
| resSigned | output | 16 | Code with bit 15 inverted (two's complement) |

## Verification
Two events can fall in the same clock cycle: the conversion-wait counter expires, and a waiting start request is accepted. The bench raises start and holds it until it sees chip select fall, so each request is present at the exact cycle the wait ends. It judges the outcome by measuring how long chip select stayed high. That time must be at least the conversion time and no more than two cycles beyond it. Stray start pulses placed in the middle of a transfer and inside the wait must leave the count of chip-select falls unchanged.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

  localparam int CMD_W = 4;

  typedef struct packed {
    logic load;      // latch command and clear the shift register
    logic capture;   // sample sdo (coincides with sck rising)
    logic shiftCmd;  // advance sdi (coincides with sck falling)
    logic publish;   // transaction finished, present result
    logic drop;      // current result is to be discarded
  } dpCtl_t;

  typedef enum logic [2:0] {
    S_CONV,
    S_IDLE,
    S_WAKE,
    S_LEAD,
    S_HIGH,
    S_LOW,
    S_TAIL
  } ctlState_t;

endpackage

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
  import adcrd_pkg::*;
#(
  parameter int CLK_KHZ  = 100000,
  parameter int CONV_US  = 23000,
  parameter int WAKE_US  = 12000,
  parameter int SCK_HALF = 4,
  parameter int DATA_W   = 16
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   cfgSleep,
  input  logic   cfgDropWake,
  output logic   csN,
  output logic   sck,
  output dpCtl_t dpCtl
);

  localparam logic [63:0] CONV_CYC = (64'(CLK_KHZ) * 64'(CONV_US)) / 64'd1000;
  localparam logic [63:0] WAKE_CYC = (64'(CLK_KHZ) * 64'(WAKE_US)) / 64'd1000;
  localparam logic [63:0] MAX_CYC  = (CONV_CYC > WAKE_CYC) ? CONV_CYC : WAKE_CYC;
  localparam int          TMR_W    = $clog2(MAX_CYC + 64'd1) + 1;
  localparam logic [TMR_W-1:0] CONV_LOAD = TMR_W'(CONV_CYC - 64'd1);
  localparam logic [TMR_W-1:0] WAKE_LOAD = TMR_W'(WAKE_CYC - 64'd1);
  localparam logic [TMR_W-1:0] HALF_LOAD = TMR_W'(SCK_HALF - 1);
  localparam int          CNT_W    = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  ctlState_t        st;
  logic [TMR_W-1:0] tmr;
  logic [CNT_W-1:0] bitCnt;
  logic             tmrDone;
  logic             wakePend;
  logic             slpCur;
  logic             dropCur;

  assign tmrDone = (tmr == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= S_CONV;
      tmr      <= CONV_LOAD;
      csN      <= 1'b1;
      sck      <= 1'b0;
      bitCnt   <= '0;
      wakePend <= 1'b0;
      slpCur   <= 1'b0;
      dropCur  <= 1'b0;
    end else begin
      case (st)
        S_CONV: begin
          if (tmrDone) st <= S_IDLE;
          else         tmr <= tmr - 1'b1;
        end
        S_IDLE: begin
          if (start) begin
            csN      <= 1'b0;
            bitCnt   <= '0;
            slpCur   <= cfgSleep;
            dropCur  <= wakePend & cfgDropWake;
            wakePend <= 1'b0;
            if (wakePend && !cfgDropWake) begin
              st  <= S_WAKE;
              tmr <= WAKE_LOAD;
            end else begin
              st  <= S_LEAD;
              tmr <= HALF_LOAD;
            end
          end
        end
        S_WAKE: begin
          if (tmrDone) begin
            st  <= S_LEAD;
            tmr <= HALF_LOAD;
          end else tmr <= tmr - 1'b1;
        end
        S_LEAD, S_LOW: begin
          if (tmrDone) begin
            sck <= 1'b1;
            st  <= S_HIGH;
            tmr <= HALF_LOAD;
          end else tmr <= tmr - 1'b1;
        end
        S_HIGH: begin
          if (tmrDone) begin
            sck <= 1'b0;
            tmr <= HALF_LOAD;
            if (bitCnt == LAST_BIT) st <= S_TAIL;
            else begin
              st     <= S_LOW;
              bitCnt <= bitCnt + 1'b1;
            end
          end else tmr <= tmr - 1'b1;
        end
        S_TAIL: begin
          if (tmrDone) begin
            csN      <= 1'b1;
            st       <= S_CONV;
            tmr      <= CONV_LOAD;
            wakePend <= slpCur;
          end else tmr <= tmr - 1'b1;
        end
        default: begin
          st  <= S_CONV;
          tmr <= CONV_LOAD;
        end
      endcase
    end
  end

  always_comb begin
    dpCtl.load     = (st == S_IDLE) && start;
    dpCtl.capture  = ((st == S_LEAD) || (st == S_LOW)) && tmrDone;
    dpCtl.shiftCmd = (st == S_HIGH) && tmrDone;
    dpCtl.publish  = (st == S_TAIL) && tmrDone;
    dpCtl.drop     = dropCur;
  end

  AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rstN) csN |-> !sck); // R3
  AST_RISE_WITH_CAPTURE: assert property (@(posedge clk) disable iff (!rstN) $rose(sck) |-> $past(dpCtl.capture)); // R3
  AST_SIXTEEN_BEFORE_END: assert property (@(posedge clk) disable iff (!rstN) dpCtl.publish |-> (bitCnt == LAST_BIT)); // R3
  AST_CS_FALL_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN) $fell(csN) |-> ($past(st) == S_IDLE)); // R9
  AST_CS_RISE_HOLDS: assert property (@(posedge clk) disable iff (!rstN) $rose(csN) |=> csN); // R6
  AST_CS_STABLE_IN_WAIT: assert property (@(posedge clk) disable iff (!rstN) (st == S_CONV) |=> $stable(csN)); // R6

endmodule

// File: rtl/adcrd_dpath.sv
module adcrd_dpath
  import adcrd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic              cfgSpeed,
  input  logic              cfgSleep,
  input  logic              sdo,
  output logic              sdi,
  output logic              resValid,
  output logic [DATA_W-1:0] resRaw,
  output logic [DATA_W-1:0] resSigned
);

  localparam int MSB = DATA_W - 1;

  logic [CMD_W-1:0]  cmdReg;
  logic [DATA_W-1:0] shReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0;
      shReg  <= '0;
    end else begin
      if (dpCtl.load) begin
        cmdReg <= {1'b1, 1'b0, cfgSpeed, cfgSleep};
        shReg  <= '0;
      end else begin
        if (dpCtl.capture)  shReg  <= {shReg[MSB-1:0], sdo};
        if (dpCtl.shiftCmd) cmdReg <= {cmdReg[CMD_W-2:0], 1'b0};
      end
    end
  end

  assign sdi = cmdReg[CMD_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      resRaw    <= '0;
      resSigned <= '0;
    end else begin
      resValid <= dpCtl.publish & ~dpCtl.drop;
      if (dpCtl.publish && !dpCtl.drop) begin
        resRaw    <= shReg;
        resSigned <= {~shReg[MSB], shReg[MSB-1:0]};
      end
    end
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN) resValid |=> !resValid); // R4
  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rstN) (dpCtl.publish && dpCtl.drop) |=> !resValid); // R8
  AST_VALID_AFTER_END: assert property (@(posedge clk) disable iff (!rstN) resValid |-> $past(dpCtl.publish)); // R4

endmodule

// File: rtl/adc_read_host.sv
module adc_read_host
  import adcrd_pkg::*;
#(
  parameter int CLK_KHZ  = 100000,
  parameter int CONV_US  = 23000,
  parameter int WAKE_US  = 12000,
  parameter int SCK_HALF = 4,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              cfgSpeed,
  input  logic              cfgSleep,
  input  logic              cfgDropWake,
  output logic              csN,
  output logic              sck,
  output logic              sdi,
  input  logic              sdo,
  output logic              resValid,
  output logic [DATA_W-1:0] resRaw,
  output logic [DATA_W-1:0] resSigned
);

  dpCtl_t dpCtl;

  adcrd_ctrl #(
    .CLK_KHZ (CLK_KHZ),
    .CONV_US (CONV_US),
    .WAKE_US (WAKE_US),
    .SCK_HALF(SCK_HALF),
    .DATA_W  (DATA_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .cfgSleep   (cfgSleep),
    .cfgDropWake(cfgDropWake),
    .csN        (csN),
    .sck        (sck),
    .dpCtl      (dpCtl)
  );

  adcrd_dpath #(
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .dpCtl    (dpCtl),
    .cfgSpeed (cfgSpeed),
    .cfgSleep (cfgSleep),
    .sdo      (sdo),
    .sdi      (sdi),
    .resValid (resValid),
    .resRaw   (resRaw),
    .resSigned(resSigned)
  );

endmodule

// File: tb/sim_adc_read_host.sv
module sim_adc_read_host;

  localparam int CLK_KHZ  = 100;
  localparam int CONV_US  = 23000;
  localparam int WAKE_US  = 12000;
  localparam int SCK_HALF = 4;
  localparam int CONV_CYC = CLK_KHZ * CONV_US / 1000;
  localparam int WAKE_CYC = CLK_KHZ * WAKE_US / 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic cfgSpeed = 1'b0;
  logic cfgSleep = 1'b0;
  logic cfgDropWake = 1'b0;
  logic sdo = 1'b0;
  logic csN, sck, sdi, resValid;
  logic [15:0] resRaw, resSigned;

  adc_read_host #(
    .CLK_KHZ(CLK_KHZ), .CONV_US(CONV_US), .WAKE_US(WAKE_US),
    .SCK_HALF(SCK_HALF), .DATA_W(16)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .cfgSpeed(cfgSpeed),
    .cfgSleep(cfgSleep), .cfgDropWake(cfgDropWake), .csN(csN), .sck(sck),
    .sdi(sdi), .sdo(sdo), .resValid(resValid), .resRaw(resRaw),
    .resSigned(resSigned)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic [15:0] raw;
    logic [15:0] sgn;
  } item_t;
  item_t sbq[$];

  // monitor: pops the scoreboard on each reported result
  logic prevValid = 1'b0;
  item_t got;
  always @(negedge clk) begin
    if (rstN && resValid) begin
      if (sbq.size() == 0) check(1'b0, "R8", "unexpected resValid", int'(resRaw), 0);
      else begin
        got = sbq.pop_front();
        check(resRaw == got.raw, "R3", "resRaw", int'(resRaw), int'(got.raw));
        check(resSigned == got.sgn, "R5", "resSigned", int'(resSigned), int'(got.sgn));
        check(csN == 1'b1, "R4", "csN at resValid", int'(csN), 1);
      end
      if (prevValid) check(1'b0, "R4", "resValid width", 2, 1);
    end
    prevValid = rstN & resValid;
  end

  // converter model and bus observer
  logic [15:0] devWord = 16'h0;
  int devIdx = 15;
  logic prevCs = 1'b1;
  logic prevSck = 1'b0;
  int riseCnt = 0;
  logic [3:0] cmdSeen = 4'h0;
  logic sdiLate = 1'b0;
  int runLen = 0;
  int phaseErr = 0;
  int leadGap = 0;
  int csFallCyc = 0;
  int csRiseCyc = 0;
  int convGap = 0;
  int fallCnt = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      prevCs = 1'b1;
      prevSck = 1'b0;
      csRiseCyc = cyc;
    end else begin
      if (prevCs && !csN) begin
        fallCnt++;
        csFallCyc = cyc;
        convGap = cyc - csRiseCyc;
        riseCnt = 0;
        cmdSeen = 4'h0;
        sdiLate = 1'b0;
        runLen = 0;
        phaseErr = 0;
        leadGap = -1;
        devIdx = 15;
        sdo = devWord[15];
      end
      if (!prevCs && csN) csRiseCyc = cyc;
      if (!csN) begin
        if (!prevSck && sck) begin
          riseCnt++;
          if (riseCnt <= 4) cmdSeen = {cmdSeen[2:0], sdi};
          else sdiLate = sdiLate | sdi;
          if (riseCnt == 1) leadGap = cyc - csFallCyc;
          else if (runLen != SCK_HALF) phaseErr++;
          runLen = 1;
        end else if (prevSck && !sck) begin
          if (runLen != SCK_HALF) phaseErr++;
          runLen = 1;
          if (devIdx > 0) begin
            devIdx--;
            sdo = devWord[devIdx];
          end
        end else runLen++;
      end
      prevCs = csN;
      prevSck = sck;
    end
  end

  // driver: one read, pushing the expected result into the scoreboard
  task automatic doRead(input logic [15:0] w, input bit spd, input bit slp,
                        input bit drop, input bit expValid, input bit expWake,
                        input bit poke);
    item_t it;
    int f0;
    devWord = w;
    cfgSpeed = spd;
    cfgSleep = slp;
    cfgDropWake = drop;
    if (expValid) begin
      it.raw = w;
      it.sgn = 16'(int'(w) - 32768);
      sbq.push_back(it);
    end
    f0 = fallCnt;
    @(negedge clk);
    start = 1'b1;
    while (fallCnt == f0) begin
      @(negedge clk);
      #1;
    end
    start = 1'b0;
    check(convGap >= CONV_CYC && convGap <= CONV_CYC + 2, "R6", "csN high gap", convGap, CONV_CYC);
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!csN) begin
      @(negedge clk);
      #1;
    end
    if (expWake)
      check(leadGap >= WAKE_CYC && leadGap <= WAKE_CYC + 2 * SCK_HALF, "R7", "wake lead gap", leadGap, WAKE_CYC);
    else
      check(leadGap >= 1 && leadGap <= 2 * SCK_HALF, "R7", "plain lead gap", leadGap, SCK_HALF);
    check(cmdSeen == {1'b1, 1'b0, spd, slp}, "R2", "command bits", int'(cmdSeen), int'({1'b1, 1'b0, spd, slp}));
    check(!sdiLate, "R2", "sdi after command", int'(sdiLate), 0);
    check(riseCnt == 16, "R3", "sck pulses", riseCnt, 16);
    check(phaseErr == 0, "R10", "sck phase errors", phaseErr, 0);
    if (poke) begin
      repeat (100) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run timed out", cyc, 200000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int fEnd;
    rstN = 1'b0;
    repeat (5) @(negedge clk);
    check(csN == 1'b1, "R1", "csN in reset", int'(csN), 1);
    check(sck == 1'b0, "R1", "sck in reset", int'(sck), 0);
    check(sdi == 1'b0, "R1", "sdi in reset", int'(sdi), 0);
    check(resValid == 1'b0, "R1", "resValid in reset", int'(resValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(csN == 1'b1 && sck == 1'b0, "R1", "idle after reset", int'({csN, sck}), 2);

    doRead(16'h8000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); // R1 wait, R5 mid-scale
    doRead(16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); // R5 full scale
    doRead(16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); // R5 zero code
    doRead(16'hA5C3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); // sleep requested
    doRead(16'h3C5A, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0); // R7 start-up delay
    doRead(16'h4001, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); // sleep again, drop mode
    doRead(16'h1234, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); // R8 discarded
    doRead(16'h4321, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0); // R8 normal after
    doRead(16'h7FFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1); // R9 stray starts

    fEnd = fallCnt;
    repeat (CONV_CYC + 50) @(negedge clk);
    check(fallCnt == 9 && fEnd == 9, "R9", "reads started", fallCnt, 9);
    check(csN == 1'b1, "R9", "csN idle after stray starts", int'(csN), 1);
    check(sbq.size() == 0, "R4", "results outstanding", sbq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule